// File: doc/BRIEF.md
# SPI Transaction Sequencer with Receive Skip

The sequencer runs one complete SPI transaction from a command word written while it is idle. The word names one of four chip selects, the total byte count, a count of leading bytes that are only transmitted, and two mode flags. A start strobe opens the transaction. The selected chip-select line is then driven active for every byte. For each byte the sequencer asks an external shift engine for one character, decides which transmit byte goes with it, and decides whether the byte received in return goes into the receive FIFO. A one-cycle done pulse closes the transaction.

The leading bytes of a receive-skip transaction carry a command taken from the transmit FIFO, and the data received during them is dropped. For the remaining bytes the sequencer supplies zero transmit bytes itself, so the transmit FIFO is not read. These bytes may optionally be received over two data lines. When a byte needs transmit data and the transmit FIFO is empty, the sequencer waits and requests nothing until data arrives. The serial clock therefore pauses, and no invalid byte is sent. Serial clock generation and chip-select setup and hold timing belong to the shift engine and are not part of this block.

Top module: `spi_xact_seq`

## Requirements
- R1: After a synchronous reset, all chip-select outputs are high and `done`, `sh_start`, `txf_pop` and `rxf_push` are low. Without a start strobe, no character is requested.
- R2: Command bits 31:30 choose the chip select. Output `cs_n[k]` is driven low for select value k, from the first request until the done cycle, and `cs_n` returns to all ones in the cycle after `done`.
- R3: Command bits 15:0 hold the total byte count minus one. Exactly that many plus one characters are requested, with one `sh_start` pulse each. This covers a single byte and counts above 256.
- R4: Command bits 23:16 hold the skip count S. When S is nonzero, bytes 0 to S-1 each pop the transmit FIFO and send the popped byte, and their received data is not stored. When S is not less than the byte count, every byte behaves this way.
- R5: When S is nonzero, every byte from index S onward sends 0x00 and does not pop the transmit FIFO.
- R6: Command bit 28 sets `sh_dual` for the bytes from index S onward. It has no effect on the skipped bytes, and it has no effect at all when S is zero.
- R7: Command bit 27 makes the transaction transmit-only: no received byte is stored for any byte.
- R8: When S is zero and bit 27 is clear, every byte pops the transmit FIFO and sends that byte. Every byte returned on `sh_rx` is pushed to the receive FIFO, in order.
- R9: When a byte needs transmit data and `txf_empty` is high, no character is requested and nothing is popped. The transaction continues once data is present.
- R10: `done` pulses for exactly one cycle, in the cycle the final character completes (`sh_done`). It pulses once per transaction. If the final byte is stored, its receive push falls in that same cycle.
- R11: While a transaction is running, command writes and start strobes are ignored. A later start without a new write repeats the earlier command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command register write enable, taken only while idle |
| cmd_data | input | 32 | Command word |
| start | input | 1 | Starts a transaction with the stored command |
| txf_empty | input | 1 | Transmit FIFO has no data |
| txf_data | input | 8 | Head of the transmit FIFO (show-ahead) |
| txf_pop | output | 1 | Removes the head of the transmit FIFO |
| rxf_push | output | 1 | Writes `rxf_data` into the receive FIFO |
| rxf_data | output | 8 | Received byte to store |
| sh_start | output | 1 | Requests one character from the shift engine |
| sh_tx | output | 8 | Byte to shift out, valid with `sh_start` |
| sh_dual | output | 1 | Receive this character over two lines, valid with `sh_start` |
| sh_done | input | 1 | Shift engine finished the current character |
| sh_rx | input | 8 | Byte received, valid with `sh_done` |
| cs_n | output | 4 | Active-low chip selects |
| done | output | 1 | Transaction-complete pulse |

## Verification
The receive-FIFO push of the last byte and the done pulse can fall in the same cycle, because both are decoded from the final `sh_done`. The bench makes this happen by ending transactions in a storing phase: plain full-duplex, post-skip receive, and a 300-byte run. Its monitor samples both outputs in one snapshot and requires the receive scoreboard queue to be empty once that cycle's push is counted. Transactions that end with no store (transmit-only, and skip counts that cover every byte) show that done still arrives when there is no push beside it.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

    localparam int SEQ_CMD_W  = 32;
    localparam int SEQ_LEN_W  = 16;
    localparam int SEQ_SKIP_W = 8;
    localparam int SEQ_SEL_W  = 2;
    localparam int SEQ_DATA_W = 8;
    localparam int SEQ_NUM_CS = 1 << SEQ_SEL_W;

    // command field placement
    localparam int F_SEL_LSB    = 30;
    localparam int F_DUAL_BIT   = 28;
    localparam int F_TXONLY_BIT = 27;
    localparam int F_SKIP_LSB   = 16;
    localparam int F_LEN_LSB    = 0;

    typedef logic [SEQ_LEN_W-1:0] idx_t;

    typedef struct packed {
        logic [SEQ_SEL_W-1:0]  sel;
        logic                  dual;
        logic                  tx_only;
        logic [SEQ_SKIP_W-1:0] skip;
        idx_t                  final_idx;
    } xact_cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT
    } seq_state_t;

    typedef struct packed {
        logic take_tx;   // byte comes from the transmit FIFO
        logic keep_rx;   // received byte goes to the receive FIFO
        logic dual;      // two-line reception for this byte
    } byte_role_t;

    function automatic xact_cmd_t decode_cmd(input logic [SEQ_CMD_W-1:0] w);
        xact_cmd_t c;
        c.sel       = w[F_SEL_LSB +: SEQ_SEL_W];
        c.dual      = w[F_DUAL_BIT];
        c.tx_only   = w[F_TXONLY_BIT];
        c.skip      = w[F_SKIP_LSB +: SEQ_SKIP_W];
        c.final_idx = w[F_LEN_LSB +: SEQ_LEN_W];
        return c;
    endfunction

    function automatic byte_role_t role_of(input xact_cmd_t c, input idx_t idx);
        byte_role_t r;
        logic       skip_mode;
        logic       in_skip;
        skip_mode = (c.skip != '0);
        in_skip   = skip_mode &&
                    (idx < {{(SEQ_LEN_W-SEQ_SKIP_W){1'b0}}, c.skip});
        r.take_tx = !skip_mode || in_skip;
        r.keep_rx = !c.tx_only && !in_skip;
        r.dual    = skip_mode && !in_skip && c.dual;
        return r;
    endfunction

endpackage

// File: rtl/spi_seq_cmd_hold.sv
module spi_seq_cmd_hold
    import spi_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [SEQ_CMD_W-1:0] wr_word,
    output xact_cmd_t            cmd_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (wr_en) begin
            cmd_q <= decode_cmd(wr_word);
        end
    end

endmodule

// File: rtl/spi_seq_byte_ctr.sv
module spi_seq_byte_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic [W-1:0] idx,
    output logic         at_limit
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            idx <= '0;
        end else if (step) begin
            idx <= idx + 1'b1;
        end
    end

    assign at_limit = (idx == limit);

endmodule

// File: rtl/spi_seq_cs_drv.sv
module spi_seq_cs_drv #(
    parameter int SEL_W = 2
) (
    input  logic                  active,
    input  logic [SEL_W-1:0]      sel,
    output logic [(1<<SEL_W)-1:0] cs_n
);

    localparam int N_LINES = 1 << SEL_W;

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        localparam logic [SEL_W-1:0] CODE = SEL_W'(g);
        assign cs_n[g] = ~(active && (sel == CODE));
    end

endmodule

// File: rtl/spi_xact_seq.sv
module spi_xact_seq
    import spi_seq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_wr,
    input  logic [SEQ_CMD_W-1:0]  cmd_data,
    input  logic                  start,
    input  logic                  txf_empty,
    input  logic [SEQ_DATA_W-1:0] txf_data,
    output logic                  txf_pop,
    output logic                  rxf_push,
    output logic [SEQ_DATA_W-1:0] rxf_data,
    output logic                  sh_start,
    output logic [SEQ_DATA_W-1:0] sh_tx,
    output logic                  sh_dual,
    input  logic                  sh_done,
    input  logic [SEQ_DATA_W-1:0] sh_rx,
    output logic [SEQ_NUM_CS-1:0] cs_n,
    output logic                  done
);

    seq_state_t st_q, st_d;
    xact_cmd_t  cmd;
    idx_t       idx;
    logic       is_last;
    logic       ctr_clr, ctr_step;
    byte_role_t role;
    logic       blocked;

    // command accepted only between transactions
    spi_seq_cmd_hold i_cmd (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cmd_wr && (st_q == ST_IDLE)),
        .wr_word (cmd_data),
        .cmd_q   (cmd)
    );

    spi_seq_byte_ctr #(.W(SEQ_LEN_W)) i_ctr (
        .clk      (clk),
        .rst      (rst),
        .clr      (ctr_clr),
        .step     (ctr_step),
        .limit    (cmd.final_idx),
        .idx      (idx),
        .at_limit (is_last)
    );

    spi_seq_cs_drv #(.SEL_W(SEQ_SEL_W)) i_cs (
        .active (st_q != ST_IDLE),
        .sel    (cmd.sel),
        .cs_n   (cs_n)
    );

    assign role    = role_of(cmd, idx);
    assign blocked = role.take_tx && txf_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d     = st_q;
        ctr_clr  = 1'b0;
        ctr_step = 1'b0;
        sh_start = 1'b0;
        txf_pop  = 1'b0;
        rxf_push = 1'b0;
        done     = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (start) begin
                    ctr_clr = 1'b1;
                    st_d    = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                // hold off the shift engine rather than send stale data
                if (!blocked) begin
                    sh_start = 1'b1;
                    txf_pop  = role.take_tx;
                    st_d     = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (sh_done) begin
                    rxf_push = role.keep_rx;
                    if (is_last) begin
                        done = 1'b1;
                        st_d = ST_IDLE;
                    end else begin
                        ctr_step = 1'b1;
                        st_d     = ST_ISSUE;
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign sh_tx    = role.take_tx ? txf_data : '0;
    assign sh_dual  = (st_q == ST_ISSUE) && !blocked && role.dual;
    assign rxf_data = sh_rx;

endmodule

// File: rtl/spi_xact_seq_chk.sv
module spi_xact_seq_chk
    import spi_seq_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  txf_empty,
    input logic                  txf_pop,
    input logic                  rxf_push,
    input logic                  sh_start,
    input logic                  sh_dual,
    input logic                  sh_done,
    input logic [SEQ_NUM_CS-1:0] cs_n,
    input logic                  done
);

    // R2
    cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

    // R2
    cs_release_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (cs_n == '1));

    // R2
    cs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((cs_n != '1) && !done) |=> $stable(cs_n));

    // R9
    no_underrun_chk: assert property (@(posedge clk) disable iff (rst)
        txf_pop |-> !txf_empty);

    // R4
    pop_with_req_chk: assert property (@(posedge clk) disable iff (rst)
        txf_pop |-> sh_start);

    // R6
    dual_zero_phase_chk: assert property (@(posedge clk) disable iff (rst)
        sh_dual |-> (sh_start && !txf_pop));

    // R8
    push_on_done_chk: assert property (@(posedge clk) disable iff (rst)
        rxf_push |-> sh_done);

    // R10
    done_on_char_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> sh_done);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

bind spi_xact_seq spi_xact_seq_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .txf_empty (txf_empty),
    .txf_pop   (txf_pop),
    .rxf_push  (rxf_push),
    .sh_start  (sh_start),
    .sh_dual   (sh_dual),
    .sh_done   (sh_done),
    .cs_n      (cs_n),
    .done      (done)
);

// File: tb/test_spi_xact_seq.sv
`timescale 1ns/1ps
module test_spi_xact_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_data = '0;
    logic        start = 1'b0;
    logic        txf_empty;
    logic [7:0]  txf_data;
    logic        txf_pop;
    logic        rxf_push;
    logic [7:0]  rxf_data;
    logic        sh_start;
    logic [7:0]  sh_tx;
    logic        sh_dual;
    logic        sh_done;
    logic [7:0]  sh_rx;
    logic [3:0]  cs_n;
    logic        done;

    always #5 clk = ~clk;

    spi_xact_seq i_spi_xact_seq (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_data(cmd_data), .start(start),
        .txf_empty(txf_empty), .txf_data(txf_data), .txf_pop(txf_pop),
        .rxf_push(rxf_push), .rxf_data(rxf_data), .sh_start(sh_start),
        .sh_tx(sh_tx), .sh_dual(sh_dual), .sh_done(sh_done), .sh_rx(sh_rx),
        .cs_n(cs_n), .done(done)
    );

    typedef struct {
        logic       pop;
        logic [7:0] txb;
        logic       dual;
    } exp_t;

    int         nchk = 0;
    int         nfail = 0;
    logic [7:0] txq[$];
    exp_t       expq[$];
    logic [7:0] exprx[$];
    logic [3:0] exp_csn = 4'hF;
    bit         done_armed = 0;
    int         done_seen = 0;
    int         eng_idx = 0;
    bit         eng_busy = 0;
    int         eng_cnt = 0;
    logic [7:0] eng_rx = '0;
    bit         last_pop = 0;
    bit         last_start = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rxpat(input int i);
        return 8'((i * 29 + 90) & 255);
    endfunction

    function automatic logic [7:0] txpat(input int seed, input int i);
        return 8'((seed * 53 + i * 37 + 7) & 255);
    endfunction

    // environment: FIFO model, shift engine model and scoreboard monitor
    initial begin
        exp_t       e;
        logic [7:0] r;
        sh_done   = 1'b0;
        sh_rx     = '0;
        txf_empty = 1'b1;
        txf_data  = '0;
        forever begin
            @(negedge clk);
            if (last_pop && txq.size() > 0) void'(txq.pop_front());
            if (last_start) begin
                eng_busy = 1;
                eng_cnt  = 2 + (eng_idx % 3);
                eng_rx   = rxpat(eng_idx);
                eng_idx++;
            end
            sh_done = 1'b0;
            if (eng_busy) begin
                eng_cnt--;
                if (eng_cnt == 0) begin
                    sh_done  = 1'b1;
                    sh_rx    = eng_rx;
                    eng_busy = 0;
                end
            end
            txf_empty = (txq.size() == 0);
            txf_data  = txf_empty ? 8'h00 : txq[0];
            #1;
            last_pop   = txf_pop;
            last_start = sh_start;
            if (!rst) begin
                if (sh_start) begin
                    if (expq.size() == 0) begin
                        check(0, "R3 extra character request", 1, 0);
                    end else begin
                        e = expq.pop_front();
                        check(txf_pop == e.pop, "R4 transmit FIFO pop", txf_pop, e.pop);
                        check(sh_tx == e.txb, "R5 transmitted byte", sh_tx, e.txb);
                        check(sh_dual == e.dual, "R6 dual flag", sh_dual, e.dual);
                        check(cs_n == exp_csn, "R2 chip select active", cs_n, exp_csn);
                        if (e.pop) check(!txf_empty, "R9 request with empty FIFO", txf_empty, 0);
                    end
                end else if (txf_pop) begin
                    check(0, "R9 pop without request", 1, 0);
                end
                if (rxf_push) begin
                    if (exprx.size() == 0) begin
                        check(0, "R7 unexpected receive store", rxf_data, 0);
                    end else begin
                        r = exprx.pop_front();
                        check(rxf_data == r, "R8 stored byte", rxf_data, r);
                    end
                end
                if (done) begin
                    check(done_armed, "R10 done only once at end", 1, done_armed);
                    check(sh_done, "R10 done with final completion", 0, 1);
                    check(expq.size() == 0, "R3 all characters requested", expq.size(), 0);
                    check(exprx.size() == 0, "R10 final store with done", exprx.size(), 0);
                    done_armed = 0;
                    done_seen++;
                end
            end
        end
    end

    task automatic run_xact(input int sel, input int last, input int skip, input bit dual,
                            input bit txonly, input int seed, input bit trickle,
                            input bit do_write, input bit disturb);
        logic [31:0] w;
        int          npop;
        int          t0;
        int          guard;
        w = (32'(sel) << 30) | (32'(dual) << 28) | (32'(txonly) << 27) |
            (32'(skip) << 16) | 32'(last);
        npop = 0;
        for (int i = 0; i <= last; i++) begin
            exp_t e;
            bit   insk;
            insk   = (skip != 0) && (i < skip);
            e.pop  = (skip == 0) || insk;
            e.txb  = e.pop ? txpat(seed, i) : 8'h00;
            e.dual = (skip != 0) && !insk && dual;
            expq.push_back(e);
            if (e.pop) npop++;
            if (!txonly && !insk) exprx.push_back(rxpat(i));
        end
        exp_csn = ~(4'b0001 << sel);
        @(posedge clk); #2;
        if (do_write) begin
            cmd_wr = 1'b1; cmd_data = w;
            @(posedge clk); #2;
            cmd_wr = 1'b0;
        end
        if (!trickle) for (int i = 0; i < npop; i++) txq.push_back(txpat(seed, i));
        eng_idx    = 0;
        done_armed = 1;
        t0         = done_seen;
        start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
        fork
            begin
                if (trickle) for (int i = 0; i < npop; i++) begin
                    repeat (7) @(posedge clk);
                    #2 txq.push_back(txpat(seed, i));
                end
            end
            begin
                if (disturb) begin
                    repeat (6) @(posedge clk);
                    #2; cmd_wr = 1'b1; cmd_data = 32'h4000_0000; start = 1'b1;
                    @(posedge clk); #2;
                    cmd_wr = 1'b0; start = 1'b0;
                end
            end
        join
        guard = 0;
        while (done_seen == t0 && guard < 20000) begin
            @(posedge clk);
            guard++;
        end
        check(done_seen == t0 + 1, "R10 transaction completed", done_seen - t0, 1);
        @(negedge clk); #2;
        check(cs_n == 4'hF, "R2 select released after done", cs_n, 4'hF);
        check(txq.size() == 0, "R4 transmit FIFO drained", txq.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #2;
        // R1 reset state
        check(cs_n == 4'hF, "R1 selects idle in reset", cs_n, 4'hF);
        check(!done && !sh_start && !txf_pop && !rxf_push, "R1 outputs quiet in reset",
              {done, sh_start, txf_pop, rxf_push}, 0);
        @(posedge clk); #2;
        rst = 1'b0;
        repeat (5) @(negedge clk);
        #2;
        check(!sh_start && cs_n == 4'hF, "R1 no request without start", {sh_start, cs_n}, 4'hF);

        run_xact(0, 4, 0, 0, 0, 1, 0, 1, 0);     // R8 plain full duplex, cs0
        run_xact(2, 0, 0, 0, 0, 2, 0, 1, 0);     // R3 single byte, cs2
        run_xact(1, 7, 3, 0, 0, 3, 0, 1, 0);     // R4 R5 skip three of eight
        run_xact(3, 5, 2, 1, 0, 4, 0, 1, 0);     // R6 dual after skip, cs3
        run_xact(0, 3, 0, 1, 0, 5, 0, 1, 0);     // R6 dual ignored without skip
        run_xact(1, 5, 0, 0, 1, 6, 0, 1, 0);     // R7 transmit-only
        run_xact(2, 5, 2, 0, 1, 7, 0, 1, 0);     // R7 transmit-only with skip
        run_xact(0, 2, 5, 1, 0, 8, 0, 1, 0);     // R4 skip covers all bytes
        run_xact(3, 5, 0, 0, 0, 9, 1, 1, 0);     // R9 stall on empty FIFO
        run_xact(1, 6, 3, 0, 0, 10, 1, 1, 0);    // R9 stall during skip phase
        run_xact(2, 299, 0, 0, 0, 11, 0, 1, 0);  // R3 long transaction
        run_xact(1, 5, 2, 1, 0, 12, 0, 1, 1);    // R11 write and start while busy
        run_xact(1, 5, 2, 1, 0, 12, 0, 0, 0);    // R11 earlier command repeated

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule